// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block sits between a processor's load port and a slower next-level memory. It holds one 32-bit word per block in two ways per set. The processor presents a byte address. The two lowest bits pick a byte inside the word, and the cache ignores them. The set field sits just above those bits, and everything higher is the tag. The tags of both ways in the chosen set are compared in parallel. On a hit, the data of the matching way comes through a select driven by the hit result, one cycle after the request.

On a miss, the block deasserts its ready output and issues a single word-aligned request to memory. It waits for a one-cycle acknowledge that carries the fill data. It then writes the word into a chosen way and returns it to the processor. Each set keeps one bit that records which way was touched most recently. When the set is full, the other way is the victim. If the set is not full, an empty way is filled first, and way 0 is tried before way 1. Because of this, two addresses that share a set can both stay resident.

Top module: `cache2w_top`

## Requirements
- R1: After reset, cpu_ready is 1, cpu_rvalid is 0, mem_req is 0 and every way is empty, so the first read of any address misses.
- R2: cpu_addr[1:0] is ignored, so addresses that differ only in those bits read the same word. The set is cpu_addr[SET_W+1:2] and the tag is the bits above it. Addresses with different set fields never evict each other.
- R3: A request accepted while cpu_ready is 1 that hits raises cpu_rvalid for exactly the next cycle with the stored word, and mem_req stays 0.
- R4: On a miss, mem_req rises and cpu_ready falls on the cycle after the request. mem_addr carries the request address with bits [1:0] cleared. Both hold until the cycle mem_ack is 1. On the next cycle cpu_rvalid is 1 with the acknowledged mem_rdata and cpu_ready is 1 again.
- R5: At most one memory request is outstanding: mem_req is 0 on the cycle after mem_ack.
- R6: A miss fills an empty way before evicting, with way 0 tried first, and a block is never resident in both ways of a set.
- R7: When both ways of a set are valid, a miss replaces the way referenced less recently, where both hits and fills count as references.
- R8: Alternating eight reads between two addresses of one set gives exactly two misses.
- R9: cpu_req is ignored while cpu_ready is 0: no extra memory request and no extra cpu_rvalid results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Read request, taken when cpu_ready is 1 |
| cpu_addr | input | ADDR_W | Byte address of the read |
| cpu_ready | output | 1 | Cache can accept a request |
| cpu_rvalid | output | 1 | Read data valid (one cycle) |
| cpu_rdata | output | DATA_W | Read data |
| mem_req | output | 1 | Fill request to next level |
| mem_addr | output | ADDR_W | Word-aligned fill address |
| mem_ack | input | 1 | One-cycle fill acknowledge |
| mem_rdata | input | DATA_W | Fill data, valid with mem_ack |

## Verification
The bench reads a word and then reads it again with different byte-offset bits, which separates word selection from byte-offset decoding. Two tags that share a set are read in turn to show that the empty way fills first and that both copies stay resident. A third tag in the same set then shows that eviction follows recency and is not fixed to one way. An alternating stream of eight reads tells a two-way cache apart from a thrashing direct-mapped one. A request held high during a miss shows whether inputs are ignored while the cache is stalled.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic {ST_IDLE, ST_FILL} cache_st_t;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int SETS   = 4,
  parameter int TAG_W  = 12,
  parameter int DATA_W = 32,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  rd_set,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS];

  // valid bits need reset; tag/data arrays are plain RAM
  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_set] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set]  <= wr_tag;
      data_mem[wr_set] <= wr_data;
    end
  end

  assign rd_valid = valid_q[rd_set];
  assign rd_tag   = tag_mem[rd_set];
  assign rd_data  = data_mem[rd_set];
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int SETS = 4,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_i,
  input  logic [1:0]       way_valid_i,
  input  logic             touch_en,
  input  logic             touch_way,
  output logic             victim_o
);
  logic [SETS-1:0] mru_q;

  always_ff @(posedge clk) begin
    if (rst) mru_q <= '0;
    else if (touch_en) mru_q[set_i] <= touch_way;
  end

  always_comb begin
    if (!way_valid_i[0])      victim_o = 1'b0;
    else if (!way_valid_i[1]) victim_o = 1'b1;
    else                      victim_o = ~mru_q[set_i];
  end

  // R7
  lru_flip_chk: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> (mru_q[$past(set_i)] == $past(touch_way)));
endmodule

// File: rtl/cache2w_top.sv
module cache2w_top #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - 2 - SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import cache2w_pkg::*;

  cache_st_t         st_q;
  logic [SET_W-1:0]  cur_set, pend_set;
  logic [TAG_W-1:0]  cur_tag, pend_tag;
  logic              pend_way;
  logic              unused_byte;
  logic [1:0]        way_valid, way_hit;
  logic [TAG_W-1:0]  way_tag  [2];
  logic [DATA_W-1:0] way_data [2];
  logic              any_hit, hit_way, victim;
  logic              fill_en, touch_en, touch_way;
  logic [SET_W-1:0]  lru_set;

  assign unused_byte = ^cpu_addr[1:0];
  assign cur_set     = cpu_addr[SET_W+1:2];
  assign cur_tag     = cpu_addr[ADDR_W-1:SET_W+2];

  assign fill_en = (st_q == ST_FILL) && mem_ack;

  for (genvar w = 0; w < 2; w++) begin : g_way
    cache2w_way #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) way_i (
      .clk     (clk),
      .rst     (rst),
      .rd_set  (cur_set),
      .rd_valid(way_valid[w]),
      .rd_tag  (way_tag[w]),
      .rd_data (way_data[w]),
      .wr_en   (fill_en && (pend_way == w[0])),
      .wr_set  (pend_set),
      .wr_tag  (pend_tag),
      .wr_data (mem_rdata)
    );
    assign way_hit[w] = way_valid[w] && (way_tag[w] == cur_tag);
  end

  assign any_hit   = |way_hit;
  assign hit_way   = way_hit[1];
  assign touch_en  = ((st_q == ST_IDLE) && cpu_req && any_hit) || fill_en;
  assign touch_way = fill_en ? pend_way : hit_way;
  assign lru_set   = fill_en ? pend_set : cur_set;

  cache2w_lru #(.SETS(SETS)) lru_i (
    .clk        (clk),
    .rst        (rst),
    .set_i      (lru_set),
    .way_valid_i(way_valid),
    .touch_en   (touch_en),
    .touch_way  (touch_way),
    .victim_o   (victim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      pend_set   <= '0;
      pend_tag   <= '0;
      pend_way   <= 1'b0;
    end else begin
      cpu_rvalid <= 1'b0;
      case (st_q)
        ST_IDLE: if (cpu_req) begin
          if (any_hit) begin
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= way_data[hit_way];
          end else begin
            st_q     <= ST_FILL;
            mem_req  <= 1'b1;
            mem_addr <= {cur_tag, cur_set, 2'b00};
            pend_set <= cur_set;
            pend_tag <= cur_tag;
            pend_way <= victim;
          end
        end
        ST_FILL: if (mem_ack) begin
          st_q       <= ST_IDLE;
          mem_req    <= 1'b0;
          cpu_rvalid <= 1'b1;
          cpu_rdata  <= mem_rdata;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready = (st_q == ST_IDLE);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (cpu_ready && !cpu_rvalid && !mem_req));
  // R4
  miss_stall_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  // R5
  single_req_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (!mem_req && cpu_rvalid));
  // R6
  no_dup_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(way_hit));
endmodule

// File: tb/cache2w_top_tb_top.sv
module cache2w_top_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cpu_req = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_ready, cpu_rvalid, mem_req;
  logic [DW-1:0] cpu_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  int n_miss  = 0;
  int lat     = 0;
  logic [DW-1:0] exp_q [$];

  always #2 clk = ~clk;

  cache2w_top #(.ADDR_W(AW), .DATA_W(DW), .SETS(4)) dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
    logic [AW-1:0] w;
    w = {a[AW-1:2], 2'b00};
    return {~w, w};
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // next-level memory: acks three cycles after a request is seen
  initial forever begin
    @(negedge clk);
    if (mem_ack) begin
      mem_ack = 1'b0;
      check(!mem_req, "R5 req drops after ack", {31'd0, mem_req}, 0);
    end else if (mem_req) begin
      if (lat == 3) begin
        mem_ack   = 1'b1;
        mem_rdata = word_of(mem_addr);
        lat       = 0;
        n_miss++;
      end else lat++;
    end
  end

  // monitor: pops scoreboard on each returned word
  initial forever begin
    @(negedge clk);
    if (!rst && cpu_rvalid) begin
      if (exp_q.size() == 0) check(0, "R9 unexpected rvalid", cpu_rdata, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(cpu_rdata == e, "R3/R4 read data", cpu_rdata, e);
      end
    end
  end

  // driver: one read, checks hit/miss timing and miss count
  task automatic do_read(input logic [AW-1:0] a, input bit exp_hit, input string req,
                         input bit hold_req = 1'b0);
    int m0;
    @(negedge clk);
    while (!cpu_ready) @(negedge clk);
    m0 = n_miss;
    cpu_req  = 1'b1;
    cpu_addr = a;
    exp_q.push_back(word_of(a));
    @(negedge clk);
    if (hold_req) cpu_addr = a ^ 16'h0008;
    else cpu_req = 1'b0;
    if (exp_hit) begin
      check(cpu_rvalid && !mem_req, {req, " hit next cycle"},
            {30'd0, cpu_rvalid, mem_req}, 2);
    end else begin
      check(mem_req && !cpu_ready && mem_addr == {a[AW-1:2], 2'b00},
            {req, " miss request"}, {16'd0, mem_addr}, {16'd0, a[AW-1:2], 2'b00});
      while (!cpu_ready) @(negedge clk);
      cpu_req = 1'b0;
    end
    repeat (2) @(negedge clk);
    check((n_miss - m0) == (exp_hit ? 0 : 1), {req, " miss count"}, n_miss - m0,
          exp_hit ? 0 : 1);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cpu_ready && !cpu_rvalid && !mem_req, "R1 reset outputs",
          {29'd0, cpu_ready, cpu_rvalid, mem_req}, 4);
    do_read(16'h0000, 0, "R1 first access");
    do_read(16'h0003, 1, "R2 byte offset ignored");
    do_read(16'h0010, 0, "R6 fill empty way");
    do_read(16'h0000, 1, "R6 way0 kept");
    do_read(16'h0010, 1, "R6 way1 kept");
    // set 0 now: 0x000 older, 0x010 recent; hit 0x000 to flip
    do_read(16'h0000, 1, "R7 touch");
    do_read(16'h0020, 0, "R7 new tag");
    do_read(16'h0000, 1, "R7 recent survives");
    do_read(16'h0010, 0, "R7 lru evicted");
    do_read(16'h0020, 0, "R7 lru evicted again");
    do_read(16'h0008, 0, "R2 other set");
    do_read(16'h0010, 1, "R2 set0 untouched");
    // R8 ping-pong in set 1
    begin
      int m0;
      m0 = n_miss;
      for (int i = 0; i < 8; i++)
        do_read((i % 2) ? 16'h0014 : 16'h0004, i >= 2, "R8 alternate");
      check(n_miss - m0 == 2, "R8 total misses", n_miss - m0, 2);
    end
    // R9: request held (address changed) during a miss
    do_read(16'h0100, 0, "R9 held request", 1'b1);
    do_read(16'h0108, 0, "R9 held address not served");
    check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule